// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This adapter sits between a processor bus and a block of peripheral registers whose registers are not all the same width. Each 4-byte region of the register space holds byte, halfword or word registers, or nothing at all. The processor may issue byte, halfword or word accesses to any offset. The adapter turns each one into accesses at the register's own width:

- A narrow read from a wider register reads the whole register and keeps the wanted lane.
- A narrow write to a wider register is a read of the register, a lane replacement and a write-back.
- A wide access to narrower registers is split into a sequence of smaller accesses.

All lane ordering is big-endian: the lowest address holds the most significant byte.

A small sequencer issues at most one register access per clock cycle. For each piece it keeps a cursor address and the number of bytes still to move, and it looks up the width of the region under the cursor. The CPU sees a one-cycle ready pulse when the whole access is finished. A single error flag reports an offset beyond the decoded window, or a region that has no registers.

Top module: `regw_adapter`

## Requirements
- R1: Only the low 10 bits of `cpu_addr` form the register offset. Higher address bits have no effect on which registers are reached or on the result.
- R2: Any piece whose offset is above 0x200 ends the access at once with `cpu_err`=1 and `cpu_rdata`=0. No register access is issued for that piece or for any later piece. Pieces completed earlier stay written. No register access ever carries an offset above 0x200.
- R3: The region width is found from offset bits [7:6]: 00 = byte, 01 = halfword, 10 = word, 11 = no registers. An access that touches a region with no registers completes with `cpu_err`=1, `cpu_rdata`=0 and no register access for that piece.
- R4: A byte read from a wider register reads that register and returns one big-endian lane. In a halfword region, an even offset gives bits 15:8 and an odd offset gives bits 7:0. In a word region, lane = offset[1:0], and lane 0 is bits 31:24.
- R5: A halfword access to a word region uses the upper 16 bits when offset[1:0]=0, and the lower 16 bits for any other offset.
- R6: A wider access is split, and each piece is judged by the width of its own region. A halfword access to a byte region becomes two byte accesses; the byte at A is the high byte and A+1 is the low byte. A word access to a non-word region becomes halfword pieces at A and then A+2; the first piece is the upper half. A halfword piece that lands in a byte region is split again into two byte accesses.
- R7: A narrow write to a wider register reads the register at its own width in one cycle. In the next cycle it writes the register back at the same address, with only the target lane replaced by the write data.
- R8: Register-side accesses always use the register's own width. `reg_size` is 0 for byte, 1 for halfword and 2 for word, and `reg_addr` is aligned to that width.
- R9: One register access is issued per cycle. `cpu_ready` is a one-cycle pulse that follows the final piece. The latency from the accepting edge to the edge that raises `cpu_ready` is one cycle per plain piece and two per read-modify-write piece. An error ends the access on the cycle of the failing piece.
- R10: `cpu_size` 0 selects byte, 1 selects halfword, and 2 or 3 selects word. Read data and write data are right-aligned in the 32-bit data buses. A completed write returns `cpu_rdata`=0.
- R11: After reset, `cpu_ready`, `cpu_err` and `reg_req` are low. A request is taken only while the adapter is idle and not in its ready cycle, so a request held through the ready pulse does not start a second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| cpu_addr | input | ADDR_W (16) | Byte address; low 10 bits used |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_rdata | output | 32 | Right-aligned read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Error flag, valid with `cpu_ready` |
| reg_req | output | 1 | Register access strobe |
| reg_we | output | 1 | Register write enable |
| reg_size | output | 2 | Native width: 0 byte, 1 halfword, 2 word |
| reg_addr | output | OFS_W (10) | Width-aligned register offset |
| reg_wdata | output | 32 | Right-aligned register write data |
| reg_rdata | input | 32 | Right-aligned register read data, same cycle as `reg_req` |

## Verification
Every result arrives at a fixed number of rising edges after the request is seen. The count is one edge to accept, one per plain piece and two per read-modify-write piece, so a word split into four bytes takes five edges and a failing piece ends the count on its own edge. The bench raises the request at a falling edge and counts rising edges until it sees `cpu_ready` at a falling edge. It compares that count, the data and the error flag with values worked out by hand from the width map. The register model in the bench records each register-side write at the edge where it happens. Those records are checked only after the ready pulse, which is when every write of the access has landed.

// File: rtl/regw_pkg.sv
package regw_pkg;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    RW_NONE = 2'd0,
    RW_BYTE = 2'd1,
    RW_HALF = 2'd2,
    RW_WORD = 2'd3
  } rwidth_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP  = 2'd1,
    ST_WBACK = 2'd2
  } state_e;

  typedef logic [2:0] nbytes_t;

  function automatic nbytes_t width_to_bytes(rwidth_e w);
    case (w)
      RW_BYTE: return 3'd1;
      RW_HALF: return 3'd2;
      RW_WORD: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic nbytes_t size_to_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] bytes_to_size(nbytes_t n);
    case (n)
      3'd1:    return 2'd0;
      3'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // Size of the next piece, given bytes still to move and the region width.
  function automatic nbytes_t pick_step(nbytes_t rem, nbytes_t wb);
    if (rem == 3'd4 && wb == 3'd4) return 3'd4;
    if (!rem[0] && wb >= 3'd2)     return 3'd2;
    return 3'd1;
  endfunction

  // Big-endian byte offset of a piece inside its native register.
  function automatic logic [1:0] lane_offset(nbytes_t e, nbytes_t wb, logic [1:0] a);
    if (e == wb)     return 2'd0;
    if (wb == 3'd2)  return {1'b0, a[0]};
    if (e == 3'd1)   return a;
    return (a == 2'd0) ? 2'd0 : 2'd2;
  endfunction

  // Distance in bytes from bit 0 of the native register to the piece.
  function automatic logic [1:0] low_shift(nbytes_t wb, logic [1:0] off, nbytes_t e);
    int s;
    s = int'(wb) - int'(off) - int'(e);
    if (s < 0) s = 0;
    return s[1:0];
  endfunction

  function automatic logic [DATA_W-1:0] keep_mask(nbytes_t e);
    case (e)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] take_bytes(logic [DATA_W-1:0] v, int lsb_byte, nbytes_t e);
    int sh;
    sh = (lsb_byte < 0) ? 0 : 8 * lsb_byte;
    return (v >> sh) & keep_mask(e);
  endfunction

  function automatic logic [DATA_W-1:0] push_bytes(logic [DATA_W-1:0] acc, logic [DATA_W-1:0] piece, nbytes_t e);
    if (e == 3'd4) return piece;
    return (acc << (8 * int'(e))) | piece;
  endfunction

endpackage

// File: rtl/regw_width_map.sv
module regw_width_map
  import regw_pkg::*;
#(
  parameter int OFS_W     = 10,
  parameter int OFS_LIMIT = 512,
  parameter int CLASS_LSB = 6
)(
  input  logic [OFS_W-1:0] ofs,
  output rwidth_e          width,
  output logic             oob
);

  logic [1:0] region_class;

  assign region_class = ofs[CLASS_LSB+1:CLASS_LSB];
  assign oob          = (ofs > OFS_W'(OFS_LIMIT));

  always_comb begin
    case (region_class)
      2'b00:   width = RW_BYTE;
      2'b01:   width = RW_HALF;
      2'b10:   width = RW_WORD;
      default: width = RW_NONE;
    endcase
  end

endmodule

// File: rtl/regw_step_plan.sv
module regw_step_plan
  import regw_pkg::*;
#(
  parameter int OFS_W = 10
)(
  input  logic [OFS_W-1:0] cur,
  input  nbytes_t          rem,
  input  rwidth_e          width,
  input  logic             oob,
  output nbytes_t          step_n,
  output nbytes_t          unit_n,
  output logic [OFS_W-1:0] unit_addr,
  output logic [1:0]       shift_n,
  output logic             bad
);

  logic [1:0] off;

  always_comb begin
    unit_n    = width_to_bytes(width);
    bad       = oob || (width == RW_NONE);
    step_n    = pick_step(rem, unit_n);
    off       = lane_offset(step_n, unit_n, cur[1:0]);
    shift_n   = low_shift(unit_n, off, step_n);
    unit_addr = cur;
    if (unit_n == 3'd2) unit_addr[0]   = 1'b0;
    if (unit_n == 3'd4) unit_addr[1:0] = 2'b00;
  end

endmodule

// File: rtl/regw_lane_unit.sv
module regw_lane_unit
  import regw_pkg::*;
(
  input  logic [DATA_W-1:0] unit_in,
  input  logic [DATA_W-1:0] piece_in,
  input  logic [1:0]        shift_n,
  input  nbytes_t           step_n,
  output logic [DATA_W-1:0] piece_out,
  output logic [DATA_W-1:0] merged
);

  logic [DATA_W-1:0] aligned;

  assign aligned   = piece_in << (8 * int'(shift_n));
  assign piece_out = take_bytes(unit_in, int'(shift_n), step_n);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic in_win;
    assign in_win = (g >= int'(shift_n)) && (g < int'(shift_n) + int'(step_n));
    assign merged[8*g +: 8] = in_win ? aligned[8*g +: 8] : unit_in[8*g +: 8];
  end

endmodule

// File: rtl/regw_adapter.sv
module regw_adapter
  import regw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFS_W     = 10,
  parameter int OFS_LIMIT = 512,
  parameter int CLASS_LSB = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              cpu_err,
  output logic              reg_req,
  output logic              reg_we,
  output logic [1:0]        reg_size,
  output logic [OFS_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);

  state_e            state_q;
  logic [OFS_W-1:0]  cur_q;
  nbytes_t           rem_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, acc_q, unit_q, rdata_q;
  logic              rdy_q, err_q;

  rwidth_e           cur_w;
  logic              cur_oob;
  nbytes_t           step_n, unit_n;
  logic [OFS_W-1:0]  unit_addr;
  logic [1:0]        shift_n;
  logic              step_bad;
  logic [DATA_W-1:0] wr_piece, rd_piece, merged, acc_next;

  // Named events for the checks below.
  logic accept_evt, err_evt, rmw_rd_evt, wback_evt, advance_evt, last_evt;

  logic unused_hi;
  assign unused_hi = ^cpu_addr[ADDR_W-1:OFS_W];

  regw_width_map #(.OFS_W(OFS_W), .OFS_LIMIT(OFS_LIMIT), .CLASS_LSB(CLASS_LSB)) u_map (
    .ofs   (cur_q),
    .width (cur_w),
    .oob   (cur_oob)
  );

  regw_step_plan #(.OFS_W(OFS_W)) u_plan (
    .cur       (cur_q),
    .rem       (rem_q),
    .width     (cur_w),
    .oob       (cur_oob),
    .step_n    (step_n),
    .unit_n    (unit_n),
    .unit_addr (unit_addr),
    .shift_n   (shift_n),
    .bad       (step_bad)
  );

  assign wr_piece = take_bytes(wdata_q, int'(rem_q) - int'(step_n), step_n);

  regw_lane_unit u_lane (
    .unit_in   (reg_rdata),
    .piece_in  (wr_piece),
    .shift_n   (shift_n),
    .step_n    (step_n),
    .piece_out (rd_piece),
    .merged    (merged)
  );

  assign acc_next    = push_bytes(acc_q, rd_piece, step_n);
  assign accept_evt  = (state_q == ST_IDLE) && cpu_req && !rdy_q;
  assign err_evt     = (state_q == ST_STEP) && step_bad;
  assign rmw_rd_evt  = (state_q == ST_STEP) && !step_bad && we_q && (step_n != unit_n);
  assign wback_evt   = (state_q == ST_WBACK);
  assign advance_evt = ((state_q == ST_STEP) && !step_bad && !rmw_rd_evt) || wback_evt;
  assign last_evt    = advance_evt && (rem_q == step_n);

  // Register-side drive.
  always_comb begin
    reg_req   = 1'b0;
    reg_we    = 1'b0;
    reg_size  = bytes_to_size(unit_n);
    reg_addr  = unit_addr;
    reg_wdata = '0;
    case (state_q)
      ST_STEP: begin
        if (!step_bad) begin
          reg_req = 1'b1;
          if (we_q && (step_n == unit_n)) begin
            reg_we    = 1'b1;
            reg_wdata = wr_piece;
          end
        end
      end
      ST_WBACK: begin
        reg_req   = 1'b1;
        reg_we    = 1'b1;
        reg_wdata = unit_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      acc_q   <= '0;
      unit_q  <= '0;
      rdata_q <= '0;
      rdy_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            cur_q   <= cpu_addr[OFS_W-1:0];
            rem_q   <= size_to_bytes(cpu_size);
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
            acc_q   <= '0;
            state_q <= ST_STEP;
          end
        end
        ST_STEP, ST_WBACK: begin
          if (err_evt) begin
            rdy_q   <= 1'b1;
            err_q   <= 1'b1;
            rdata_q <= '0;
            state_q <= ST_IDLE;
          end else if (rmw_rd_evt) begin
            unit_q  <= merged;
            state_q <= ST_WBACK;
          end else begin
            if (!we_q) acc_q <= acc_next;
            cur_q   <= cur_q + OFS_W'(step_n);
            rem_q   <= rem_q - step_n;
            state_q <= ST_STEP;
            if (last_evt) begin
              rdy_q   <= 1'b1;
              err_q   <= 1'b0;
              rdata_q <= we_q ? '0 : acc_next;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = rdy_q;
  assign cpu_err   = err_q;
  assign cpu_rdata = rdata_q;

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R9
  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_err) |-> (cpu_rdata == '0)); // R3
  AST_REG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> (reg_addr <= OFS_W'(OFS_LIMIT))); // R2
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> !reg_req); // R2
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_size == 2'd2) |-> (reg_addr[1:0] == 2'b00)); // R8
  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_size == 2'd1) |-> (reg_addr[0] == 1'b0)); // R8
  AST_WBACK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wback_evt |-> ($past(rmw_rd_evt) && $stable(reg_addr) && $stable(reg_size))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !reg_req); // R11

endmodule

// File: tb/regw_adapter_bench.sv
module regw_adapter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [15:0] cpu_addr = 16'h0;
  logic [31:0] cpu_wdata = 32'h0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready, cpu_err;
  logic        reg_req, reg_we;
  logic [1:0]  reg_size;
  logic [9:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  regw_adapter u_regw_adapter (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_err(cpu_err),
    .reg_req(reg_req), .reg_we(reg_we), .reg_size(reg_size),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Register-side model: byte storage, big-endian native views.
  logic [7:0]  mem [0:1023];
  int          wr_count = 0;
  logic [9:0]  last_wr_addr = '0;
  logic [1:0]  last_wr_size = '0;
  logic [31:0] last_wr_data = '0;

  always_comb begin
    int a;
    a = int'(reg_addr);
    case (reg_size)
      2'd0:    reg_rdata = {24'h0, mem[a]};
      2'd1:    reg_rdata = {16'h0, mem[a], mem[(a+1) & 1023]};
      default: reg_rdata = {mem[a], mem[(a+1) & 1023], mem[(a+2) & 1023], mem[(a+3) & 1023]};
    endcase
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'(i);
    end else if (reg_req && reg_we) begin
      int a;
      a = int'(reg_addr);
      case (reg_size)
        2'd0: mem[a] <= reg_wdata[7:0];
        2'd1: begin
          mem[a]   <= reg_wdata[15:8];
          mem[a+1] <= reg_wdata[7:0];
        end
        default: begin
          mem[a]   <= reg_wdata[31:24];
          mem[a+1] <= reg_wdata[23:16];
          mem[a+2] <= reg_wdata[15:8];
          mem[a+3] <= reg_wdata[7:0];
        end
      endcase
      wr_count     <= wr_count + 1;
      last_wr_addr <= reg_addr;
      last_wr_size <= reg_size;
      last_wr_data <= reg_wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic [1:0] sz, input logic we, input logic [15:0] addr,
                           input logic [31:0] wd, output logic [31:0] rd,
                           output logic er, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_size = sz; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (cpu_ready) break;
      if (lat > 40) begin
        check("R9 ready timeout", 32'(lat), 32'd0);
        break;
      end
    end
    rd = cpu_rdata;
    er = cpu_err;
    cpu_req = 1'b0;
  endtask

  // {size[54:53], addr[52:37], data[36:5], err[4], latency[3:0]}
  localparam int NV = 24;
  localparam logic [54:0] VEC [0:NV-1] = '{
    {2'd0, 16'h0005, 32'h0000_0005, 1'b0, 4'd2},  // R1 native byte
    {2'd1, 16'h0010, 32'h0000_1011, 1'b0, 4'd3},  // R6 half on bytes
    {2'd2, 16'h0020, 32'h2021_2223, 1'b0, 4'd5},  // R6 word on bytes
    {2'd1, 16'h0044, 32'h0000_4445, 1'b0, 4'd2},  // native half
    {2'd0, 16'h0045, 32'h0000_0045, 1'b0, 4'd2},  // R4 odd lane
    {2'd0, 16'h0046, 32'h0000_0046, 1'b0, 4'd2},  // R4 even lane
    {2'd2, 16'h0048, 32'h4849_4A4B, 1'b0, 4'd3},  // R6 word on halves
    {2'd2, 16'h0084, 32'h8485_8687, 1'b0, 4'd2},  // native word
    {2'd1, 16'h0084, 32'h0000_8485, 1'b0, 4'd2},  // R5 upper
    {2'd1, 16'h0086, 32'h0000_8687, 1'b0, 4'd2},  // R5 lower
    {2'd1, 16'h0085, 32'h0000_8687, 1'b0, 4'd2},  // R5 odd offset
    {2'd0, 16'h0081, 32'h0000_0081, 1'b0, 4'd2},  // R4 word lane 1
    {2'd0, 16'h0087, 32'h0000_0087, 1'b0, 4'd2},  // R4 word lane 3
    {2'd0, 16'h00C4, 32'h0000_0000, 1'b1, 4'd2},  // R3 empty region
    {2'd2, 16'h00C0, 32'h0000_0000, 1'b1, 4'd2},  // R3 empty region
    {2'd0, 16'h0201, 32'h0000_0000, 1'b1, 4'd2},  // R2 above limit
    {2'd0, 16'h0200, 32'h0000_0000, 1'b0, 4'd2},  // R2 at limit
    {2'd2, 16'h003E, 32'h3E3F_4041, 1'b0, 4'd4},  // R6 crosses regions
    {2'd0, 16'hA405, 32'h0000_0005, 1'b0, 4'd2},  // R1 high bits ignored
    {2'd2, 16'h0200, 32'h0000_0000, 1'b1, 4'd3},  // R2 error mid-sequence
    {2'd2, 16'h007E, 32'h7E7F_8081, 1'b0, 4'd3},  // R6 half then word region
    {2'd3, 16'h0088, 32'h8889_8A8B, 1'b0, 4'd2},  // R10 size 3 is word
    {2'd1, 16'h0101, 32'h0000_0102, 1'b0, 4'd3},  // R6 unaligned half on bytes
    {2'd1, 16'h0200, 32'h0000_0000, 1'b1, 4'd3}   // R2 second byte out of range
  };

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    int          lat;
    int          w0;

    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset ready", {31'h0, cpu_ready}, 32'h0);
    check("R11 reset err", {31'h0, cpu_err}, 32'h0);
    check("R11 reset reg_req", {31'h0, reg_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = VEC[i];
      do_access(v[54:53], 1'b0, v[52:37], 32'h0, rd, er, lat);
      check($sformatf("R4 R5 R6 R10 vector %0d data", i), rd, v[36:5]);
      check($sformatf("R2 R3 vector %0d err", i), {31'h0, er}, {31'h0, v[4]});
      check($sformatf("R9 vector %0d latency", i), 32'(lat), {28'h0, v[3:0]});
    end

    // R7: byte write into halfword register
    w0 = wr_count;
    do_access(2'd0, 1'b1, 16'h0045, 32'h0000_00AB, rd, er, lat);
    check("R7 byte rmw latency", 32'(lat), 32'd3);
    check("R7 byte rmw writes", 32'(wr_count - w0), 32'd1);
    check("R7 byte rmw addr", {22'h0, last_wr_addr}, 32'h44);
    check("R8 byte rmw size", {30'h0, last_wr_size}, 32'd1);
    check("R7 byte rmw data", last_wr_data, 32'h0000_44AB);
    check("R10 write rdata", rd, 32'h0);

    // R5 R7: halfword write into word register
    do_access(2'd1, 1'b1, 16'h0086, 32'h0000_1234, rd, er, lat);
    check("R7 half rmw latency", 32'(lat), 32'd3);
    check("R5 half rmw data", last_wr_data, 32'h8485_1234);
    check("R8 half rmw addr", {22'h0, last_wr_addr}, 32'h84);

    // R6: word write split into bytes, then read back
    w0 = wr_count;
    do_access(2'd2, 1'b1, 16'h0010, 32'hDEAD_BEEF, rd, er, lat);
    check("R6 byte split writes", 32'(wr_count - w0), 32'd4);
    check("R6 byte split latency", 32'(lat), 32'd5);
    do_access(2'd2, 1'b0, 16'h0010, 32'h0, rd, er, lat);
    check("R6 byte split readback", rd, 32'hDEAD_BEEF);

    // R6: word write split into halves
    w0 = wr_count;
    do_access(2'd2, 1'b1, 16'h0048, 32'hCAFE_F00D, rd, er, lat);
    check("R6 half split writes", 32'(wr_count - w0), 32'd2);
    check("R6 half split last addr", {22'h0, last_wr_addr}, 32'h4A);
    check("R6 half split last data", last_wr_data, 32'h0000_F00D);

    // R4 R7: byte write into word register, read back
    do_access(2'd0, 1'b1, 16'h008B, 32'h0000_0077, rd, er, lat);
    check("R7 word rmw latency", 32'(lat), 32'd3);
    do_access(2'd2, 1'b0, 16'h0088, 32'h0, rd, er, lat);
    check("R4 word lane readback", rd, 32'h8889_8A77);

    // R3: write into empty region touches nothing
    w0 = wr_count;
    do_access(2'd0, 1'b1, 16'h00D0, 32'h0000_0055, rd, er, lat);
    check("R3 empty write err", {31'h0, er}, 32'h1);
    check("R3 empty write count", 32'(wr_count - w0), 32'd0);

    // R2: word write whose second byte is out of range
    w0 = wr_count;
    do_access(2'd2, 1'b1, 16'h0200, 32'h1122_3344, rd, er, lat);
    check("R2 partial write err", {31'h0, er}, 32'h1);
    check("R2 partial write count", 32'(wr_count - w0), 32'd1);
    check("R2 partial write byte", {24'h0, mem[512]}, 32'h11);
    check("R2 partial write latency", 32'(lat), 32'd3);

    // R8: native word write
    do_access(2'd2, 1'b1, 16'h0084, 32'hA5A5_A5A5, rd, er, lat);
    check("R8 native word latency", 32'(lat), 32'd2);
    check("R8 native word size", {30'h0, last_wr_size}, 32'd2);

    // R11: request held through the ready pulse starts nothing new
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 2'd0; cpu_addr = 16'h0005;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (cpu_ready) break;
    end
    @(posedge clk);
    @(negedge clk);
    check("R11 held request ready", {31'h0, cpu_ready}, 32'h0);
    check("R11 held request reg_req", {31'h0, reg_req}, 32'h0);
    cpu_req = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule